// File: doc/BRIEF.md
# Configuration Store Access Controller

This block sits between a programming port and the configuration storage of a small programmable logic device. A host issues one command at a time over a synchronous interface: it can program a fuse row, read a fuse row back for verification, read or write one byte of a 64-bit user signature, set the lock bit, force values into the macrocell registers, or erase the whole store. Each command holds the block busy for a fixed number of cycles. It then finishes with a one-cycle completion pulse, read data where the command returns any, and an error flag.

The lock bit is one-way during normal operation. Once set, fuse readback and register forcing are refused from the very next command onward. The signature stays readable and writable, and fuse rows can still be programmed. Only a full erase clears the lock bit, and the erase also wipes the fuse rows and the signature. Register forcing presents an eight-bit value and an eight-bit select mask to the macrocell registers. Only the selected registers take the value.

Top module: `cfgmem_ctrl`

## Requirements
- R1: After reset, busy, done, err, rd_data, pl_strobe, pl_value and secured are all zero, every fuse row reads as zero and every signature byte reads as zero.
- R2: A command is accepted on a rising clock edge where cmd_valid is high and busy is low, and busy is high in the cycle after acceptance. A command presented while busy is high is dropped and changes no stored state.
- R3: Opcodes on cmd_op are 0 program row, 1 verify row, 2 signature read, 3 signature write, 4 set lock, 5 register force, 6 erase, and 7 reserved. Every command ends with done high for exactly one cycle with busy low in that cycle. A new command may be accepted in that same cycle.
- R4: Program row ORs cmd_wdata into the fuse row selected by cmd_addr. This is permitted whether or not the lock is set.
- R5: Verify row with the lock clear returns the selected row on rd_data with err low.
- R6: Signature write replaces byte cmd_addr[2:0] with cmd_wdata[7:0]. Signature read returns that byte on rd_data[7:0] with the upper bits zero and err low. Both commands work whether or not the lock is set.
- R7: Set lock drives secured high at its completion. A verify issued in the done cycle of the set-lock command is already refused.
- R8: Verify row with the lock set returns rd_data all zeros with err high.
- R9: Register force with the lock clear pulses pl_strobe equal to cmd_mask for exactly the done cycle and sets pl_value to cmd_wdata[7:0]. With the lock set, pl_strobe stays zero and err is high.
- R10: Erase clears all fuse rows, all signature bytes and the lock. No other command lowers secured.
- R11: Commands that return no data leave rd_data zero at completion. The reserved opcode completes with err high. rd_data and err hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 3 | Fuse row index or signature byte index |
| cmd_wdata | input | 32 | Program data, signature byte in [7:0], force value in [7:0] |
| cmd_mask | input | 8 | Register select mask for register force |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command refused or invalid |
| rd_data | output | 32 | Data returned by the last completed command |
| pl_value | output | 8 | Value forced into the macrocell registers |
| pl_strobe | output | 8 | Per-register load strobe |
| secured | output | 1 | Lock bit state |

## Verification
Two events can land on the same edge. One is the completion of a command. The other is the acceptance of the next command, because the host may raise cmd_valid during the done cycle. The bench provokes this by issuing every vector of its table back to back, with each new request driven in the previous command's done cycle. The sharpest case is set-lock followed immediately by verify, which must return zeros with err high. A second coincidence is a request raised while busy is high. The bench judges this one by reading the targeted signature byte afterwards and finding it unchanged.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_VERIFY  = 3'd1,
    OP_SIGRD   = 3'd2,
    OP_SIGWR   = 3'd3,
    OP_LOCK    = 3'd4,
    OP_FORCE   = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  localparam int SIG_BYTE_W = 8;

endpackage

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
  import cfgmem_pkg::*;
#(
  parameter int OP_CYCLES    = 3,
  parameter int ERASE_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  op_e  cmd_op,
  output logic accept,
  output logic exec,
  output logic busy,
  output logic done
);

  localparam int MAXC  = (ERASE_CYCLES > OP_CYCLES) ? ERASE_CYCLES : OP_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept = cmd_valid & ~busy_q;
  assign exec   = busy_q & (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = (cmd_op == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(OP_CYCLES - 1);
    end else if (exec) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store
  import cfgmem_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int ROW_W     = 32,
  parameter int SIG_BYTES = 8,
  localparam int ROW_AW   = $clog2(ROWS),
  localparam int SIG_AW   = $clog2(SIG_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec,
  input  op_e                   op,
  input  logic [ROW_AW-1:0]     row_addr,
  input  logic [SIG_AW-1:0]     sig_addr,
  input  logic [ROW_W-1:0]      wdata,
  output logic [ROW_W-1:0]      row_rd,
  output logic [SIG_BYTE_W-1:0] sig_rd,
  output logic                  secured
);

  logic [ROW_W-1:0]      fuse_q [ROWS];
  logic [SIG_BYTE_W-1:0] sig_q  [SIG_BYTES];
  logic                  lock_q, lock_d;
  logic                  wipe;

  assign wipe = exec & (op == OP_ERASE);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic             we;
    logic [ROW_W-1:0] nxt;
    assign we = exec & (op == OP_PROG) & (row_addr == ROW_AW'(r));
    always_comb begin
      nxt = fuse_q[r];
      if (wipe)    nxt = '0;
      else if (we) nxt = fuse_q[r] | wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fuse_q[r] <= '0;
      else if (wipe | we)  fuse_q[r] <= nxt;
    end
  end

  for (genvar b = 0; b < SIG_BYTES; b++) begin : g_sig
    logic                  we;
    logic [SIG_BYTE_W-1:0] nxt;
    assign we = exec & (op == OP_SIGWR) & (sig_addr == SIG_AW'(b));
    always_comb begin
      nxt = sig_q[b];
      if (wipe)    nxt = '0;
      else if (we) nxt = wdata[SIG_BYTE_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sig_q[b] <= '0;
      else if (wipe | we)  sig_q[b] <= nxt;
    end
  end

  always_comb begin
    lock_d = lock_q;
    if (wipe)                          lock_d = 1'b0;
    else if (exec && (op == OP_LOCK))  lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign row_rd  = fuse_q[row_addr];
  assign sig_rd  = sig_q[sig_addr];
  assign secured = lock_q;

endmodule

// File: rtl/cfgmem_force.sv
module cfgmem_force #(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [NREG-1:0] value,
  input  logic [NREG-1:0] mask,
  output logic [NREG-1:0] pl_value,
  output logic [NREG-1:0] pl_strobe
);

  logic [NREG-1:0] val_q, val_d;
  logic [NREG-1:0] stb_q, stb_d;

  always_comb begin
    val_d = val_q;
    stb_d = '0;
    if (fire) begin
      val_d = value;
      stb_d = mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      stb_q <= '0;
    end else begin
      val_q <= val_d;
      stb_q <= stb_d;
    end
  end

  assign pl_value  = val_q;
  assign pl_strobe = stb_q;

endmodule

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl
  import cfgmem_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int ROW_W        = 32,
  parameter int SIG_BYTES    = 8,
  parameter int NREG         = 8,
  parameter int OP_CYCLES    = 3,
  parameter int ERASE_CYCLES = 6,
  localparam int ROW_AW      = $clog2(ROWS),
  localparam int SIG_AW      = $clog2(SIG_BYTES),
  localparam int ADDR_W      = (ROW_AW > SIG_AW) ? ROW_AW : SIG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ROW_W-1:0]  cmd_wdata,
  input  logic [NREG-1:0]   cmd_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ROW_W-1:0]  rd_data,
  output logic [NREG-1:0]   pl_value,
  output logic [NREG-1:0]   pl_strobe,
  output logic              secured
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic accept, exec;

  cfgmem_seq #(
    .OP_CYCLES   (OP_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .cmd_valid(cmd_valid),
    .cmd_op   (op_e'(cmd_op)),
    .accept   (accept),
    .exec     (exec),
    .busy     (busy),
    .done     (done)
  );

  // captured command
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ROW_W-1:0]  wdata_q, wdata_d;
  logic [NREG-1:0]   mask_q, mask_d;

  always_comb begin
    op_d    = op_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    mask_d  = mask_q;
    if (accept) begin
      op_d    = op_e'(cmd_op);
      addr_d  = cmd_addr;
      wdata_d = cmd_wdata;
      mask_d  = cmd_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      op_q    <= OP_PROG;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      mask_q  <= mask_d;
    end
  end

  logic [ROW_W-1:0]      row_rd;
  logic [SIG_BYTE_W-1:0] sig_rd;
  logic                  lock;

  cfgmem_store #(
    .ROWS     (ROWS),
    .ROW_W    (ROW_W),
    .SIG_BYTES(SIG_BYTES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync),
    .exec    (exec),
    .op      (op_q),
    .row_addr(addr_q[ROW_AW-1:0]),
    .sig_addr(addr_q[SIG_AW-1:0]),
    .wdata   (wdata_q),
    .row_rd  (row_rd),
    .sig_rd  (sig_rd),
    .secured (lock)
  );

  logic fire;
  assign fire = exec & (op_q == OP_FORCE) & ~lock;

  cfgmem_force #(
    .NREG(NREG)
  ) u_force (
    .clk      (clk),
    .rst_n    (rst_sync),
    .fire     (fire),
    .value    (wdata_q[NREG-1:0]),
    .mask     (mask_q),
    .pl_value (pl_value),
    .pl_strobe(pl_strobe)
  );

  // completion result
  logic [ROW_W-1:0] rd_q, rd_d;
  logic             err_q, err_d;

  always_comb begin
    rd_d  = '0;
    err_d = 1'b0;
    unique case (op_q)
      OP_VERIFY: begin
        if (lock) err_d = 1'b1;
        else      rd_d  = row_rd;
      end
      OP_SIGRD:  rd_d  = {{(ROW_W - SIG_BYTE_W){1'b0}}, sig_rd};
      OP_FORCE:  err_d = lock;
      OP_RSVD:   err_d = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else if (exec) begin
      rd_q  <= rd_d;
      err_q <= err_d;
    end
  end

  assign rd_data = rd_q;
  assign err     = err_q;
  assign secured = lock;

endmodule

// File: rtl/cfgmem_ctrl_chk.sv
module cfgmem_ctrl_chk #(
  parameter int ROW_W = 32,
  parameter int NREG  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [ROW_W-1:0] rd_data,
  input logic [NREG-1:0]  pl_strobe,
  input logic             secured
);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && $past(rst_n)) |=> (busy || done));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rd_data == '0));

  // R9
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_strobe != '0) |-> (done && !secured && !err));

  // R10
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secured) |-> done);

endmodule

bind cfgmem_ctrl cfgmem_ctrl_chk #(
  .ROW_W(ROW_W),
  .NREG (NREG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .rd_data  (rd_data),
  .pl_strobe(pl_strobe),
  .secured  (secured)
);

// File: tb/test_cfgmem_ctrl.sv
module test_cfgmem_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  cmd_mask = '0;
  logic        busy, done, err, secured;
  logic [31:0] rd_data;
  logic [7:0]  pl_value, pl_strobe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cfgmem_ctrl i_cfgmem_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .pl_value(pl_value), .pl_strobe(pl_strobe), .secured(secured)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  adr;
    logic [31:0] wd;
    logic [7:0]  msk;
    logic [31:0] rd;
    logic        er;
    logic [7:0]  stb;
    logic [7:0]  plv;
    logic        sc;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 3'd2, 32'h0000_00F0, 8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R4
    '{3'd0, 3'd2, 32'h0000_0F00, 8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R4
    '{3'd1, 3'd2, 32'h0,         8'h00, 32'h0000_0FF0, 1'b0, 8'h00, 8'h00, 1'b0}, // R5
    '{3'd1, 3'd5, 32'h0,         8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R5
    '{3'd3, 3'd3, 32'h0000_00A5, 8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R6
    '{3'd2, 3'd3, 32'h0,         8'h00, 32'h0000_00A5, 1'b0, 8'h00, 8'h00, 1'b0}, // R6
    '{3'd3, 3'd3, 32'h0000_013C, 8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R6
    '{3'd2, 3'd3, 32'h0,         8'h00, 32'h0000_003C, 1'b0, 8'h00, 8'h00, 1'b0}, // R6
    '{3'd5, 3'd0, 32'h0000_005A, 8'h0F, 32'h0,        1'b0, 8'h0F, 8'h5A, 1'b0}, // R9
    '{3'd5, 3'd0, 32'h0000_00A3, 8'hF0, 32'h0,        1'b0, 8'hF0, 8'hA3, 1'b0}, // R9
    '{3'd4, 3'd0, 32'h0,         8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b1}, // R7
    '{3'd1, 3'd2, 32'h0,         8'h00, 32'h0,        1'b1, 8'h00, 8'h00, 1'b1}, // R8
    '{3'd2, 3'd3, 32'h0,         8'h00, 32'h0000_003C, 1'b0, 8'h00, 8'h00, 1'b1}, // R6
    '{3'd5, 3'd0, 32'h0000_00FF, 8'hFF, 32'h0,        1'b1, 8'h00, 8'h00, 1'b1}, // R9
    '{3'd0, 3'd2, 32'hF000_0000, 8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b1}, // R4
    '{3'd6, 3'd0, 32'h0,         8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R10
    '{3'd1, 3'd2, 32'h0,         8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R10
    '{3'd2, 3'd3, 32'h0,         8'h00, 32'h0,        1'b0, 8'h00, 8'h00, 1'b0}, // R10
    '{3'd7, 3'd0, 32'h0,         8'h00, 32'h0,        1'b1, 8'h00, 8'h00, 1'b0}  // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, hold over one rising edge, then wait for done
  task automatic run_cmd(input logic [2:0] op, input logic [2:0] adr,
                         input logic [31:0] wd, input logic [7:0] msk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = adr; cmd_wdata = wd; cmd_mask = msk;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 pl_strobe", 32'(pl_strobe), 32'd0);
    chk("R1 pl_value", 32'(pl_value), 32'd0);
    chk("R1 secured", 32'(secured), 32'd0);
    run_cmd(3'd1, 3'd7, 32'h0, 8'h0);
    chk("R1 row erased", rd_data, 32'd0);
    run_cmd(3'd2, 3'd6, 32'h0, 8'h0);
    chk("R1 signature erased", rd_data, 32'd0);

    // R3 done lasts one cycle
    @(negedge clk);
    chk("R3 done one cycle", 32'(done), 32'd0);

    // R2 busy after accept; request while busy dropped
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 3'd1; cmd_wdata = 32'h11; cmd_mask = '0;
    @(negedge clk);
    chk("R2 busy after accept", 32'(busy), 32'd1);
    cmd_op = 3'd3; cmd_addr = 3'd1; cmd_wdata = 32'h22;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R3 busy low at done", 32'(busy), 32'd0);
    run_cmd(3'd2, 3'd1, 32'h0, 8'h0);
    chk("R2 dropped write", rd_data, 32'h11);

    // table walk: each request is driven in the previous done cycle (R3, R7)
    for (int i = 0; i < NV; i++) begin
      run_cmd(TBL[i].op, TBL[i].adr, TBL[i].wd, TBL[i].msk);
      chk($sformatf("R11 vec%0d rd_data", i), rd_data, TBL[i].rd);
      chk($sformatf("R11 vec%0d err", i), 32'(err), 32'(TBL[i].er));
      chk($sformatf("R9 vec%0d pl_strobe", i), 32'(pl_strobe), 32'(TBL[i].stb));
      chk($sformatf("R10 vec%0d secured", i), 32'(secured), 32'(TBL[i].sc));
      if (TBL[i].stb != 8'h00)
        chk($sformatf("R9 vec%0d pl_value", i), 32'(pl_value), 32'(TBL[i].plv));
    end

    // R9 strobe lasts only the done cycle; R11 outputs hold
    @(negedge clk);
    chk("R9 strobe idle", 32'(pl_strobe), 32'd0);
    chk("R11 err held", 32'(err), 32'd1);

    // R7 lock then verify in the done cycle, after programming a row
    run_cmd(3'd0, 3'd4, 32'h0000_BEEF, 8'h0);
    run_cmd(3'd1, 3'd4, 32'h0, 8'h0);
    chk("R5 verify row4", rd_data, 32'h0000_BEEF);
    run_cmd(3'd4, 3'd0, 32'h0, 8'h0);
    run_cmd(3'd1, 3'd4, 32'h0, 8'h0);
    chk("R7 immediate refusal err", 32'(err), 32'd1);
    chk("R7 immediate refusal data", rd_data, 32'd0);
    run_cmd(3'd3, 3'd0, 32'h77, 8'h0);
    run_cmd(3'd2, 3'd0, 32'h0, 8'h0);
    chk("R6 signature while locked", rd_data, 32'h77);
    chk("R10 lock persists", 32'(secured), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule